// File: doc/BRIEF.md
# Chip-Enable Gate with Write Completion

This block sits on the active-low chip-enable path between a processor and a battery-backed RAM. While the supervisor reset is low, the gate is transparent. The chip-enable output follows the input with no clock latency. While the supervisor reset is high, the gate is closed and the output is held high (inactive). A failing supply therefore cannot produce a spurious RAM access.

If the reset rises while the processor holds chip-enable low, the block assumes a write is under way and keeps the gate open for a bounded grace window. The window length is given as a clock-cycle count, derived from a clock rate and a time in microseconds. The gate closes at the end of the window, or earlier, as soon as the processor raises chip-enable. Once closed, the gate stays closed until the reset has been released and the input has been sampled inactive.

Top module: `ce_guard`

## Requirements
- R1: While the gate is open (`gate_open` = 1), `ce_out_n` equals `ce_in_n` in the same cycle, with no register on the path.
- R2: A clock edge that samples `rst` = 1 and `ce_in_n` = 0 while the gate is passing starts a grace window. The gate stays open and passes the input for the next GRACE_CYC cycles (GRACE_CYC = CLK_MHZ × GRACE_US).
- R3: If `ce_in_n` is still low when the window ends, the gate closes. From the edge after the last grace cycle onward, `gate_open` = 0 and `ce_out_n` = 1.
- R4: An edge that samples `ce_in_n` = 1 during the grace window closes the gate from that edge onward, before the window ends.
- R5: While the gate is closed, `ce_out_n` is 1 and `gate_open` is 0 whatever `ce_in_n` does, including a new falling edge after a completed write.
- R6: An edge that samples `rst` = 1 and `ce_in_n` = 1 while the gate is passing closes the gate at once, with no grace window.
- R7: A closed gate reopens only on an edge that samples `rst` = 0 and `ce_in_n` = 1. With the reset released but the input held low, the gate stays closed.
- R8: During power-up, with `rst` high from the first clock edge, the gate is closed and `ce_out_n` stays 1 regardless of `ce_in_n`.
- R9: The grace counter starts from zero on every entry into the window, so each new reset episode gets the full GRACE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Supervisor reset, active high, sampled synchronously |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| ce_out_n | output | 1 | Gated chip-enable to the RAM, active low |
| gate_open | output | 1 | High while the gate passes chip-enable |

## Verification
The hardest situation to reach is the boundary between an early release and an expired window. It needs a reset that rises mid-write, followed by a chip-enable rise on one exact cycle relative to the window's end. The bench shrinks the window to four cycles and sweeps the release cycle from the first grace cycle to one past the last. Each sweep point is a fresh reset episode that starts from a reopened gate. Every episode re-lowers chip-enable after the release, to show that the closed gate ignores it.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;

    // Closed is encoded as zero so that an uninitialised register powers up closed.
    typedef enum logic [1:0] {
        ST_BLOCKED = 2'd0,
        ST_PASS    = 2'd1,
        ST_GRACE   = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic open;
        logic ce_n;
    } gate_out_t;

    function automatic int grace_cycles(input int mhz, input int usec);
        return (mhz * usec < 1) ? 1 : mhz * usec;
    endfunction

    function automatic int cnt_width(input int cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/ce_guard_timer.sv
module ce_guard_timer
    import ce_guard_pkg::*;
#(
    parameter int GRACE_CYC = 900
) (
    input  logic clk,
    input  logic run,
    output logic expired
);
    localparam int CW = cnt_width(GRACE_CYC);
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Held at zero outside the window, so every entry starts fresh.
    always_ff @(posedge clk) begin
        if (!run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/ce_guard_fsm.sv
module ce_guard_fsm
    import ce_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_in_n,
    input  logic     expired,
    output gate_st_e st
);
    gate_st_e st_q, st_d;

    always_comb begin
        case (st_q)
            ST_PASS: begin
                if (!rst)
                    st_d = ST_PASS;
                else if (ce_in_n)
                    st_d = ST_BLOCKED;
                else
                    st_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (ce_in_n || expired)
                    st_d = ST_BLOCKED;
                else
                    st_d = ST_GRACE;
            end
            ST_BLOCKED: begin
                if (!rst && ce_in_n)
                    st_d = ST_PASS;
                else
                    st_d = ST_BLOCKED;
            end
            default: st_d = ST_BLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/ce_guard_mux.sv
module ce_guard_mux
    import ce_guard_pkg::*;
(
    input  gate_st_e  st,
    input  logic      ce_in_n,
    output gate_out_t out
);
    always_comb begin
        out.open = (st == ST_PASS) || (st == ST_GRACE);
        out.ce_n = out.open ? ce_in_n : 1'b1;
    end
endmodule

// File: rtl/ce_guard.sv
module ce_guard
    import ce_guard_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int GRACE_US = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic gate_open
);
    localparam int GRACE_CYC = grace_cycles(CLK_MHZ, GRACE_US);

    gate_st_e  st_q;
    logic      expired;
    gate_out_t gout;

    ce_guard_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ce_in_n (ce_in_n),
        .expired (expired),
        .st      (st_q)
    );

    ce_guard_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
        .clk     (clk),
        .run     (st_q == ST_GRACE),
        .expired (expired)
    );

    ce_guard_mux u_mux (
        .st      (st_q),
        .ce_in_n (ce_in_n),
        .out     (gout)
    );

    assign ce_out_n  = gout.ce_n;
    assign gate_open = gout.open;
endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk
    import ce_guard_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int GRACE_US = 18
) (
    input logic     clk,
    input logic     rst,
    input logic     ce_in_n,
    input logic     ce_out_n,
    input logic     gate_open,
    input gate_st_e st
);
    localparam int GRACE_CYC = grace_cycles(CLK_MHZ, GRACE_US);

    logic        primed = 1'b0;
    int unsigned gcnt   = 0;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b1;
        gcnt <= (st == ST_GRACE) ? gcnt + 1 : 0;
    end

    AST_REASSERT_MIDWRITE: assert property (@(posedge clk) disable iff (!primed)
        (st == ST_PASS && rst && !ce_in_n) |=> (st == ST_GRACE)); // R2
    AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!primed)
        (st == ST_GRACE) |-> (gcnt < GRACE_CYC)); // R3
    AST_EARLY_CLOSE: assert property (@(posedge clk) disable iff (!primed)
        (st == ST_GRACE && ce_in_n) |=> (st == ST_BLOCKED)); // R4
    AST_CLOSED_HIGH: assert property (@(posedge clk) disable iff (!primed)
        (st == ST_BLOCKED) |-> (ce_out_n && !gate_open)); // R5
    AST_IDLE_CLOSE: assert property (@(posedge clk) disable iff (!primed)
        (gate_open && st == ST_PASS && rst && ce_in_n) |=> !gate_open); // R6
    AST_STAY_CLOSED: assert property (@(posedge clk) disable iff (!primed)
        (st == ST_BLOCKED && (rst || !ce_in_n)) |=> (st == ST_BLOCKED)); // R7
endmodule

bind ce_guard ce_guard_chk #(.CLK_MHZ(CLK_MHZ), .GRACE_US(GRACE_US)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_in_n   (ce_in_n),
    .ce_out_n  (ce_out_n),
    .gate_open (gate_open),
    .st        (st_q)
);

// File: tb/sim_ce_guard.sv
module sim_ce_guard;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ = 1;
    localparam int US  = 4;
    localparam int G   = MHZ * US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_in_n = 1'b1;
    logic ce_out_n, gate_open;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ce_guard #(.CLK_MHZ(MHZ), .GRACE_US(US)) u0 (
        .clk       (clk),
        .rst       (rst),
        .ce_in_n   (ce_in_n),
        .ce_out_n  (ce_out_n),
        .gate_open (gate_open)
    );

    task automatic chk(input logic [1:0] exp, input string tag);
        n_run++;
        if ({gate_open, ce_out_n} !== exp) begin
            n_fail++;
            $display("FAIL %s: {gate_open,ce_out_n} actual %b expected %b",
                     tag, {gate_open, ce_out_n}, exp);
        end
    endtask

    task automatic drive(input logic r, input logic c);
        @(negedge clk);
        rst = r;
        ce_in_n = c;
        #1;
    endtask

    initial begin
        // R8: supervisor reset held from power-up, input toggling
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, i[0]);
            chk(2'b01, "R8 power-up closed");
        end
        for (int k = 1; k <= G + 1; k++) begin
            // R7: released reset with input low keeps the gate closed
            drive(1'b0, 1'b0); chk(2'b01, "R7 released, input low");
            drive(1'b0, 1'b0); chk(2'b01, "R7 still closed");
            drive(1'b0, 1'b1); chk(2'b01, "R7 before reopen edge");
            drive(1'b0, 1'b1); chk(2'b11, "R7 reopened");
            // R1: transparent passing
            drive(1'b0, 1'b0); chk(2'b10, "R1 pass low");
            drive(1'b0, 1'b1); chk(2'b11, "R1 pass high");
            drive(1'b0, 1'b0); chk(2'b10, "R1 pass low again");
            // reset rises mid-write
            drive(1'b1, 1'b0); chk(2'b10, "R2 reset cycle still passing");
            for (int n = 1; n <= G + 2; n++) begin
                logic c, open;
                string tag;
                c    = (n == k);
                open = (n <= G) && (n <= k);
                if (open)
                    tag = (k > 1) ? "R9 fresh grace window (R2)" : "R2 grace passing";
                else if (n > k)
                    tag = "R4 closed after release, R5 ignores fall";
                else
                    tag = "R3 window expired";
                drive(1'b1, c);
                chk({open, open ? c : 1'b1}, tag);
            end
        end
        // R6: reset with input idle closes without grace
        drive(1'b0, 1'b1); chk(2'b01, "R7 before reopen edge");
        drive(1'b0, 1'b1); chk(2'b11, "R7 reopened");
        drive(1'b1, 1'b1); chk(2'b11, "R6 reset cycle");
        drive(1'b1, 1'b0); chk(2'b01, "R6 no grace window");
        drive(1'b1, 1'b0); chk(2'b01, "R5 closed ignores input");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule